// File: doc/BRIEF.md
# Masked Value and Edge Comparator

This unit is one event source for the trigger logic of a logic analyzer. Each clock it may receive one sample word, marked by a valid strobe. It raises a single-bit event when the sample, restricted to the bits selected by a mask, meets a programmed condition. Bits outside the mask never prevent a match.

The condition depends on the mode. In value mode the selected bits must equal a reference word. In edge mode each selected bit must sit at its reference level. Any bit also marked in an edge-enable word must, in addition, have changed since the previous valid sample. Several such units feed a trigger sequencer. A range check is formed by pairing two units, one programmed for each limit, so a unit compares against one limit only.

The event is registered and appears in the cycle after the sample that caused it. Configuration is read in the same cycle as the valid sample it applies to. The remembered previous sample is discarded when the mode changes and is not valid after reset. In both cases edge qualification is withheld until a fresh previous sample exists.

Top module: `evt_match_unit`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `evt_o` is 0.
- R2: With `cfg_mode_i` = 0 (value mode), a valid sample yields `evt_o` = 1 in the next cycle exactly when `(smp_i ^ cfg_ref_i) & cfg_mask_i` is zero. Otherwise `evt_o` is 0 in that cycle.
- R3: Bits with `cfg_mask_i` = 0 always count as matching. An all-zero mask gives an event on every valid sample in value mode, and on every valid sample in edge mode.
- R4: A cycle with `smp_valid_i` = 0 gives `evt_o` = 0 in the next cycle. Such a cycle does not replace the remembered previous sample.
- R5: With `cfg_mode_i` = 1 (edge mode), a masked bit matches when it equals its `cfg_ref_i` bit. If its `cfg_edge_i` bit is 1, it must also differ from the same bit of the previous valid sample. The event is the AND over all bits.
- R6: The first valid sample after reset has no previous sample. In edge mode that sample gives no event if any masked bit is edge-enabled.
- R7: A change of `cfg_mode_i` discards the previous sample. The first valid sample taken in or after the cycle of the change is then judged with edge qualification failing. Value-mode results are unaffected by this.
- R8: Mask, reference, edge-enable and mode are used as presented in the cycle of each valid sample. A change applies from the next valid sample on.
- R9: In edge mode with `cfg_edge_i` all zero, the unit matches on the level of the masked bits alone, as in value mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | DATA_W | Sample word |
| cfg_mode_i | input | 1 | 0 = value match, 1 = edge match |
| cfg_mask_i | input | DATA_W | 1 selects a bit for comparison |
| cfg_ref_i | input | DATA_W | Reference value or required level after transition |
| cfg_edge_i | input | DATA_W | 1 requires the bit to have just changed (edge mode) |
| evt_o | output | 1 | Registered event, one cycle after the sample |

## Verification
A mode change and a valid sample can arrive in the same cycle. In that case the sample must be judged in the new mode with its edge qualification failing, and it must become the new previous sample. The bench sets this up by flipping `cfg_mode_i` in the same vector as a sample. Without the discard, that sample would fire on a real transition against the old history, so the bench expects no event. It then expects an event from the next sample, which toggles against the one just stored. A separate directed test toggles the mode twice with no sample in between. After that it checks that the discard alone blocks the next edge.

// File: rtl/evt_match_pkg.sv
package evt_match_pkg;

    typedef enum logic {
        MODE_VALUE = 1'b0,
        MODE_EDGE  = 1'b1
    } cmp_mode_e;

    // configuration seen by one bit lane
    typedef struct packed {
        logic sel;
        logic lvl;
        logic need_chg;
    } lane_cfg_t;

    // sample context seen by one bit lane
    typedef struct packed {
        logic cur;
        logic old;
        logic hist_ok;
    } lane_smp_t;

    function automatic logic lane_hit(input cmp_mode_e mode,
                                      input lane_cfg_t c,
                                      input lane_smp_t s);
        logic lvl_ok;
        logic chg_ok;
        lvl_ok = (s.cur == c.lvl);
        chg_ok = s.hist_ok && (s.cur != s.old);
        if (!c.sel)
            return 1'b1;
        if (mode == MODE_VALUE)
            return lvl_ok;
        return lvl_ok && (!c.need_chg || chg_ok);
    endfunction

    function automatic int unsigned ceil_div(input int unsigned a,
                                             input int unsigned b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/evt_hist_reg.sv
module evt_hist_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              drop_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] prev_o,
    output logic              have_o
);

    logic [DATA_W-1:0] prev_q;
    logic              have_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (load_i) begin
            // a sample in the cycle of a mode change becomes the new history
            prev_q <= din_i;
            have_q <= 1'b1;
        end else if (drop_i) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end
    end

    assign prev_o = prev_q;
    assign have_o = have_q;

endmodule

// File: rtl/evt_bit_lanes.sv
module evt_bit_lanes
    import evt_match_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  cmp_mode_e         mode_i,
    input  logic              hist_ok_i,
    input  logic [DATA_W-1:0] cur_i,
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] lvl_i,
    input  logic [DATA_W-1:0] chg_i,
    output logic [DATA_W-1:0] hit_o
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        lane_cfg_t c;
        lane_smp_t s;
        always_comb begin
            c.sel      = mask_i[b];
            c.lvl      = lvl_i[b];
            c.need_chg = chg_i[b];
            s.cur      = cur_i[b];
            s.old      = old_i[b];
            s.hist_ok  = hist_ok_i;
            hit_o[b]   = lane_hit(mode_i, c, s);
        end
    end

endmodule

// File: rtl/evt_reduce.sv
module evt_reduce
    import evt_match_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned GRP_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] hit_i,
    output logic              evt_o
);

    localparam int unsigned N_GRP = ceil_div(DATA_W, GRP_W);
    localparam int unsigned PAD_W = N_GRP * GRP_W;

    logic [PAD_W-1:0] hit_pad;
    logic [N_GRP-1:0] grp_all;
    logic             evt_q;

    // unused padding lanes count as matching
    always_comb begin
        hit_pad         = '1;
        hit_pad[DATA_W-1:0] = hit_i;
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_all[g] = &hit_pad[g*GRP_W +: GRP_W];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            evt_q <= 1'b0;
        else
            evt_q <= valid_i && (&grp_all);
    end

    assign evt_o = evt_q;

endmodule

// File: rtl/evt_match_unit.sv
module evt_match_unit
    import evt_match_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned GRP_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_i,
    input  logic              cfg_mode_i,
    input  logic [DATA_W-1:0] cfg_mask_i,
    input  logic [DATA_W-1:0] cfg_ref_i,
    input  logic [DATA_W-1:0] cfg_edge_i,
    output logic              evt_o
);

    cmp_mode_e         mode_now;
    cmp_mode_e         mode_q;
    logic              mode_chg;
    logic [DATA_W-1:0] prev;
    logic              have_prev;
    logic              hist_ok;
    logic [DATA_W-1:0] hit;

    assign mode_now = cmp_mode_e'(cfg_mode_i);
    assign mode_chg = (mode_now != mode_q);
    assign hist_ok  = have_prev && !mode_chg;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            mode_q <= MODE_VALUE;
        else
            mode_q <= mode_now;
    end

    evt_hist_reg #(
        .DATA_W (DATA_W)
    ) u_hist (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (smp_valid_i),
        .drop_i (mode_chg),
        .din_i  (smp_i),
        .prev_o (prev),
        .have_o (have_prev)
    );

    evt_bit_lanes #(
        .DATA_W (DATA_W)
    ) u_lanes (
        .mode_i    (mode_now),
        .hist_ok_i (hist_ok),
        .cur_i     (smp_i),
        .old_i     (prev),
        .mask_i    (cfg_mask_i),
        .lvl_i     (cfg_ref_i),
        .chg_i     (cfg_edge_i),
        .hit_o     (hit)
    );

    evt_reduce #(
        .DATA_W (DATA_W),
        .GRP_W  (GRP_W)
    ) u_reduce (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (smp_valid_i),
        .hit_i   (hit),
        .evt_o   (evt_o)
    );

endmodule

// File: rtl/evt_match_chk.sv
module evt_match_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              smp_valid_i,
    input logic [DATA_W-1:0] smp_i,
    input logic              cfg_mode_i,
    input logic [DATA_W-1:0] cfg_mask_i,
    input logic [DATA_W-1:0] cfg_ref_i,
    input logic [DATA_W-1:0] cfg_edge_i,
    input logic              evt_o
);

    logic [DATA_W-1:0] last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            last_q <= '0;
        else if (smp_valid_i)
            last_q <= smp_i;
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> !evt_o);

    // R2
    value_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_i && !cfg_mode_i) |=>
            (evt_o == $past(((smp_i ^ cfg_ref_i) & cfg_mask_i) == '0)));

    // R3
    open_mask_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_i && cfg_mask_i == '0) |=> evt_o);

    // R4
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_valid_i |=> !evt_o);

    // R5
    edge_need_chg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_i && cfg_mode_i &&
         (((smp_i ^ last_q) & cfg_edge_i & cfg_mask_i) != (cfg_edge_i & cfg_mask_i)))
            |=> !evt_o);

    // R5
    edge_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_i && cfg_mode_i && (((smp_i ^ cfg_ref_i) & cfg_mask_i) != '0))
            |=> !evt_o);

endmodule

bind evt_match_unit evt_match_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .smp_valid_i (smp_valid_i),
    .smp_i       (smp_i),
    .cfg_mode_i  (cfg_mode_i),
    .cfg_mask_i  (cfg_mask_i),
    .cfg_ref_i   (cfg_ref_i),
    .cfg_edge_i  (cfg_edge_i),
    .evt_o       (evt_o)
);

// File: tb/evt_match_unit_bench.sv
module evt_match_unit_bench;

    localparam int unsigned W = 32;

    typedef struct packed {
        logic         mode;
        logic         valid;
        logic [W-1:0] data;
        logic [W-1:0] mask;
        logic [W-1:0] refv;
        logic [W-1:0] een;
        logic         expv;
        logic [3:0]   req;
    } vec_t;

    localparam int N_VEC = 17;
    localparam vec_t VECS [N_VEC] = '{
        // R2 exact value match
        '{1'b0, 1'b1, 32'h12345678, 32'hFFFFFFFF, 32'h12345678, 32'h0, 1'b1, 4'd2},
        // R2 one bit off
        '{1'b0, 1'b1, 32'h12345679, 32'hFFFFFFFF, 32'h12345678, 32'h0, 1'b0, 4'd2},
        // R3 upper bits masked off
        '{1'b0, 1'b1, 32'hABCD0078, 32'h000000FF, 32'h00000078, 32'h0, 1'b1, 4'd3},
        // R3 all-zero mask
        '{1'b0, 1'b1, 32'hDEADBEEF, 32'h00000000, 32'h00000000, 32'h0, 1'b1, 4'd3},
        // R4 matching word without strobe
        '{1'b0, 1'b0, 32'hDEADBEEF, 32'h00000000, 32'h00000000, 32'h0, 1'b0, 4'd4},
        // R7 switch to edge mode with a sample: edge withheld
        '{1'b1, 1'b1, 32'h00000001, 32'h00000001, 32'h00000001, 32'h1, 1'b0, 4'd7},
        // R5 falling to required level 0
        '{1'b1, 1'b1, 32'h00000000, 32'h00000001, 32'h00000000, 32'h1, 1'b1, 4'd5},
        // R5 no change
        '{1'b1, 1'b1, 32'h00000000, 32'h00000001, 32'h00000000, 32'h1, 1'b0, 4'd5},
        // R4 invalid sample must not become history
        '{1'b1, 1'b0, 32'h00000001, 32'h00000001, 32'h00000001, 32'h1, 1'b0, 4'd4},
        // R4 rise against history 0 still seen
        '{1'b1, 1'b1, 32'h00000001, 32'h00000001, 32'h00000001, 32'h1, 1'b1, 4'd4},
        // R5 change but wrong level
        '{1'b1, 1'b1, 32'h00000000, 32'h00000001, 32'h00000001, 32'h1, 1'b0, 4'd5},
        // R9 level only in edge mode
        '{1'b1, 1'b1, 32'h000000A5, 32'h000000F0, 32'h000000A0, 32'h0, 1'b1, 4'd9},
        // R3 open mask in edge mode
        '{1'b1, 1'b1, 32'h00000000, 32'h00000000, 32'h00000001, 32'h1, 1'b1, 4'd3},
        // R7 back to value mode, unaffected
        '{1'b0, 1'b1, 32'h00000005, 32'h0000000F, 32'h00000005, 32'h0, 1'b1, 4'd7},
        // R7 to edge mode: real fall of bit0 vs 5, yet withheld
        '{1'b1, 1'b1, 32'h00000004, 32'h00000001, 32'h00000000, 32'h1, 1'b0, 4'd7},
        // R7 history now 4, rise is seen
        '{1'b1, 1'b1, 32'h00000005, 32'h00000001, 32'h00000001, 32'h1, 1'b1, 4'd7},
        // R8 edge enable dropped in same cycle as sample
        '{1'b1, 1'b1, 32'h00000005, 32'h00000001, 32'h00000001, 32'h0, 1'b1, 4'd8}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         smp_valid;
    logic [W-1:0] smp;
    logic         cfg_mode;
    logic [W-1:0] cfg_mask;
    logic [W-1:0] cfg_ref;
    logic [W-1:0] cfg_edge;
    logic         evt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    evt_match_unit #(.DATA_W(W)) u_evt_match_unit (
        .clk_i       (clk),
        .rst_i       (rst),
        .smp_valid_i (smp_valid),
        .smp_i       (smp),
        .cfg_mode_i  (cfg_mode),
        .cfg_mask_i  (cfg_mask),
        .cfg_ref_i   (cfg_ref),
        .cfg_edge_i  (cfg_edge),
        .evt_o       (evt)
    );

    task automatic check(input int req, input logic expv, input string what);
        checks++;
        if (evt !== expv) begin
            errors++;
            $display("FAIL R%0d %s: evt_o=%b expected %b", req, what, evt, expv);
        end
    endtask

    task automatic drive(input logic m, input logic v, input logic [W-1:0] d,
                         input logic [W-1:0] mk, input logic [W-1:0] rf,
                         input logic [W-1:0] ee);
        cfg_mode  = m;
        smp_valid = v;
        smp       = d;
        cfg_mask  = mk;
        cfg_ref   = rf;
        cfg_edge  = ee;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1;
        drive(m, 1'b0, '0, '0, '0, '0);
        check(1, 1'b0, "during reset");
        rst = 1'b0;
        drive(m, 1'b0, '0, '0, '0, '0);
        check(1, 1'b0, "after reset");
    endtask

    initial begin
        rst = 1'b1;
        smp_valid = 1'b0;
        smp = '0;
        cfg_mode = 1'b0;
        cfg_mask = '0;
        cfg_ref = '0;
        cfg_edge = '0;
        @(negedge clk);
        do_reset(1'b0);   // R1

        for (int i = 0; i < N_VEC; i++) begin
            drive(VECS[i].mode, VECS[i].valid, VECS[i].data,
                  VECS[i].mask, VECS[i].refv, VECS[i].een);
            check(int'(VECS[i].req), VECS[i].expv, $sformatf("vector %0d", i));
        end

        // R6 first sample after reset in edge mode
        do_reset(1'b1);
        drive(1'b1, 1'b1, 32'h1, 32'h1, 32'h1, 32'h1);
        check(6, 1'b0, "first edge sample after reset");
        drive(1'b1, 1'b1, 32'h0, 32'h1, 32'h0, 32'h1);
        check(6, 1'b1, "second edge sample after reset");

        // R7 mode toggled twice without samples drops history
        drive(1'b1, 1'b1, 32'h1, 32'h1, 32'h1, 32'h1);
        check(5, 1'b1, "rise before toggle");
        drive(1'b0, 1'b0, 32'h0, 32'h1, 32'h0, 32'h1);
        check(4, 1'b0, "idle toggle");
        drive(1'b1, 1'b0, 32'h0, 32'h1, 32'h0, 32'h1);
        check(4, 1'b0, "idle toggle back");
        drive(1'b1, 1'b1, 32'h0, 32'h1, 32'h0, 32'h1);
        check(7, 1'b0, "fall after history drop");
        drive(1'b1, 1'b1, 32'h1, 32'h1, 32'h1, 32'h1);
        check(7, 1'b1, "rise after re-prime");

        // R2 wide pattern, single mismatch in top bit
        drive(1'b0, 1'b1, 32'h80000000, 32'h80000000, 32'h0, 32'h0);
        check(2, 1'b0, "top bit mismatch");
        // R8 reference change applies on this sample
        drive(1'b0, 1'b1, 32'h80000000, 32'h80000000, 32'h80000000, 32'h0);
        check(8, 1'b1, "new reference used");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired: evt_o=%b expected completion", evt);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule